// File: doc/BRIEF.md
# DMA Channel Interrupt Coalescer

This block holds the control and status registers for one direction of a descriptor-driven DMA channel and decides when that channel raises its interrupt. The data mover signals each finished packet with a one-cycle completion pulse. The block counts these pulses against a programmable packet threshold. A delay timer covers the case where completions stop short of the threshold. A separate error pulse raises an error event at once. Software sees three status events, enables each one separately, and acknowledges them by writing ones back.

Because every event arrives as a single-cycle pulse, there is no data stream into or out of the block and no back-pressure. A pulse in a cycle where it is not accepted is dropped and never held back. The register port is a plain write strobe with address and data. Reads are combinational from the address. The control register also carries a run bit, which is exported to the datapath, and a soft reset. The soft reset flushes the channel for a fixed number of cycles and then clears itself.

Register map, by byte offset: `0x0` is control, `0x4` is status. Other offsets read as zero and ignore writes.

Top module: `coal_irq_unit`

## Requirements
- R1: After reset, control reads 0xFE18_0000: wait bound 254 in bits 31:24, threshold 24 in bits 23:16, all enables 0 and run 0. Status reads 0 and `irq` is 0.
- R2: Control bits 31:24 (wait bound), 23:16 (threshold), 14 (error enable), 13 (delay enable), 12 (completion enable) and 0 (run) read back as written. Bit 2 reads 1 only during a flush. Every other bit reads 0.
- R3: While running, each completion pulse raises the pending count. The pulse that brings the count to the threshold sets status bit 12 at that same clock edge and returns the count to zero. A threshold of 0 acts as 1.
- R4: Completion pulses that arrive while the run bit is 0 leave the pending count unchanged.
- R5: With a nonzero pending count and a nonzero wait bound D, status bit 13 sets D*PRESCALE cycles after the latest accepted completion. Every accepted completion restarts this wait. Expiry returns the pending count to zero. A wait bound of 0 disables the timer.
- R6: An error pulse sets status bit 14, whether or not the channel is running.
- R7: Writing a 1 to status bit 12, 13 or 14 clears that bit, and writing a 0 leaves it unchanged. An event that arrives in the same cycle as the clearing write keeps the bit set.
- R8: `irq` is high exactly when some status bit is set together with its enable bit: bit 12 with control bit 12, 13 with 13, 14 with 14.
- R9: Writing 1 to control bit 2 starts a flush of FLUSH_CYCLES cycles, during which bit 2 reads 1. During the flush, register writes, completion pulses and error pulses are ignored. When the flush ends, control returns to its reset value and status, the pending count and the timer are cleared.
- R10: `chan_run` follows control bit 0 and is 0 during a flush. `chan_flushing` is 1 exactly during a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pkt_done | input | 1 | One-cycle pulse per completed packet |
| dma_err | input | 1 | One-cycle pulse per channel error |
| irq | output | 1 | Channel interrupt |
| chan_run | output | 1 | Channel may run |
| chan_flushing | output | 1 | Soft reset flush in progress |

## Verification
A completion or error pulse that is sampled at a clock edge shows up in status and `irq` right after that same edge. A timer expiry lands exactly D*PRESCALE edges after the last accepted completion. A flush ends FLUSH_CYCLES edges after the write that starts it. The bench counts the edges since each stimulus and reads the registers half a cycle after the edge of interest. It samples the delay and flush boundaries one edge before the event as well as on the event edge, so a result that arrives one cycle early or late is caught. Expected values go into a queue when a check is issued. A monitor compares them on the falling clock edge.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int FIELD_W   = 8;
  localparam int BIT_RUN   = 0;
  localparam int BIT_SRST  = 2;
  localparam int BIT_DONE  = 12;   // enable and status share positions
  localparam int BIT_DLY   = 13;
  localparam int BIT_ERR   = 14;
  localparam int THR_LSB   = 16;
  localparam int DLY_LSB   = 24;

  localparam logic [FIELD_W-1:0] THR_DEFAULT = 8'd24;
  localparam logic [FIELD_W-1:0] DLY_DEFAULT = 8'd254;

  localparam int OFS_CTRL = 0;
  localparam int OFS_STAT = 4;

  typedef struct packed {
    logic [FIELD_W-1:0] dly;
    logic [FIELD_W-1:0] thr;
    logic               ie_err;
    logic               ie_dly;
    logic               ie_done;
    logic               run;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{dly: DLY_DEFAULT, thr: THR_DEFAULT,
                                   ie_err: 1'b0, ie_dly: 1'b0,
                                   ie_done: 1'b0, run: 1'b0};
endpackage

// File: rtl/coal_flush.sv
module coal_flush #(
  parameter int FLUSH_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic fin
);
  localparam int FL_W = $clog2(FLUSH_CYCLES + 1);

  logic [FL_W-1:0] left;

  // R9: busy for exactly FLUSH_CYCLES cycles after the starting edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      left <= '0;
    end else if (!busy && start) begin
      busy <= 1'b1;
      left <= FL_W'(FLUSH_CYCLES - 1);
    end else if (busy) begin
      if (left == '0) busy <= 1'b0;
      else            left <= left - 1'b1;
    end
  end

  assign fin = busy && (left == '0);
endmodule

// File: rtl/coal_pace.sv
module coal_pace #(
  parameter int PRESCALE = 8,
  parameter int FW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          done,
  input  logic [FW-1:0] thr,
  input  logic [FW-1:0] dly,
  output logic [FW-1:0] pend,
  output logic          set_done,
  output logic          set_dly
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [FW-1:0] tmr;
  logic [FW:0]   thr_eff, pend_inc, tmr_inc;
  logic          run_tmr, tick;

  assign thr_eff  = (thr == '0) ? (FW+1)'(1) : {1'b0, thr};   // R3 zero acts as one
  assign pend_inc = {1'b0, pend} + 1'b1;
  assign tmr_inc  = {1'b0, tmr} + 1'b1;
  assign run_tmr  = !clear && (pend != '0) && (dly != '0);   // R5 zero disables

  generate
    if (PRESCALE == 1) begin : g_noscale
      assign tick = run_tmr;
    end else begin : g_scale
      logic [PRE_W-1:0] pre;
      assign tick = run_tmr && (pre == PRE_W'(PRESCALE - 1));
      always_ff @(posedge clk) begin
        if (!rst_n || done || !run_tmr || tick) pre <= '0;
        else                                    pre <= pre + 1'b1;
      end
    end
  endgenerate

  assign set_done = done && (pend_inc >= thr_eff);
  assign set_dly  = tick && !done && (tmr_inc >= {1'b0, dly});

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      pend <= '0;
      tmr  <= '0;
    end else if (done) begin
      pend <= set_done ? '0 : pend_inc[FW-1:0];
      tmr  <= '0;                                  // R5 restart
    end else if (tick) begin
      if (set_dly) begin
        pend <= '0;
        tmr  <= '0;
      end else begin
        tmr  <= tmr_inc[FW-1:0];
      end
    end
  end
endmodule

// File: rtl/coal_regs.sv
module coal_regs
  import coal_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic        wr_stat,
  input  logic [31:0] wdata,
  input  logic        flushing,
  input  logic        flush_end,
  input  logic        set_done,
  input  logic        set_dly,
  input  logic        set_err,
  output ctrl_t       ctrl_q,
  output logic [2:0]  stat_q
);
  logic [2:0] stat_n;

  always_ff @(posedge clk) begin
    if (!rst_n || flush_end) begin
      ctrl_q <= CTRL_RESET;
    end else if (wr_ctrl && !flushing) begin
      ctrl_q.dly     <= wdata[DLY_LSB +: FIELD_W];
      ctrl_q.thr     <= wdata[THR_LSB +: FIELD_W];
      ctrl_q.ie_err  <= wdata[BIT_ERR];
      ctrl_q.ie_dly  <= wdata[BIT_DLY];
      ctrl_q.ie_done <= wdata[BIT_DONE];
      ctrl_q.run     <= wdata[BIT_RUN];
    end
  end

  // R7: write-one-to-clear, a new event wins over a clear in the same cycle
  always_comb begin
    stat_n = stat_q;
    if (wr_stat && !flushing) stat_n = stat_n & ~wdata[BIT_ERR:BIT_DONE];
    stat_n = stat_n | {set_err, set_dly, set_done};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush_end) stat_q <= '0;
    else                     stat_q <= stat_n;
  end
endmodule

// File: rtl/coal_irq_unit.sv
module coal_irq_unit
  import coal_pkg::*;
#(
  parameter int PRESCALE     = 8,
  parameter int FLUSH_CYCLES = 16,
  parameter int ADDR_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              pkt_done,
  input  logic              dma_err,
  output logic              irq,
  output logic              chan_run,
  output logic              chan_flushing
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  ctrl_t              ctrl_q;
  logic [2:0]         stat_q;
  logic [FIELD_W-1:0] pend_cnt, dly_cfg, thr_cfg;
  logic               wr_ctrl, wr_stat, flush_start, flush_end;
  logic               done_ok, set_done, set_dly, set_err;
  logic               unused_wdata;

  assign unused_wdata = ^{reg_wdata[31:15], reg_wdata[11:1]};

  assign wr_ctrl     = reg_wr && (reg_addr == A_CTRL);
  assign wr_stat     = reg_wr && (reg_addr == A_STAT);
  assign flush_start = wr_ctrl && reg_wdata[BIT_SRST] && !chan_flushing;
  assign chan_run    = ctrl_q.run && !chan_flushing;               // R10
  assign done_ok     = pkt_done && chan_run;                        // R4
  assign set_err     = dma_err && !chan_flushing;                   // R6
  assign dly_cfg     = ctrl_q.dly;
  assign thr_cfg     = ctrl_q.thr;

  coal_flush #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_flush (
    .clk(clk), .rst_n(rst_n), .start(flush_start),
    .busy(chan_flushing), .fin(flush_end)
  );

  coal_pace #(.PRESCALE(PRESCALE), .FW(FIELD_W)) u_pace (
    .clk(clk), .rst_n(rst_n), .clear(chan_flushing), .done(done_ok),
    .thr(thr_cfg), .dly(dly_cfg), .pend(pend_cnt),
    .set_done(set_done), .set_dly(set_dly)
  );

  coal_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_stat(wr_stat),
    .wdata(reg_wdata), .flushing(chan_flushing), .flush_end(flush_end),
    .set_done(set_done), .set_dly(set_dly), .set_err(set_err),
    .ctrl_q(ctrl_q), .stat_q(stat_q)
  );

  // R8
  assign irq = |(stat_q & {ctrl_q.ie_err, ctrl_q.ie_dly, ctrl_q.ie_done});

  // R2 readback layout
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL) begin
      reg_rdata[DLY_LSB +: FIELD_W] = ctrl_q.dly;
      reg_rdata[THR_LSB +: FIELD_W] = ctrl_q.thr;
      reg_rdata[BIT_ERR]            = ctrl_q.ie_err;
      reg_rdata[BIT_DLY]            = ctrl_q.ie_dly;
      reg_rdata[BIT_DONE]           = ctrl_q.ie_done;
      reg_rdata[BIT_SRST]           = chan_flushing;
      reg_rdata[BIT_RUN]            = ctrl_q.run;
    end else if (reg_addr == A_STAT) begin
      reg_rdata[BIT_ERR:BIT_DONE]   = stat_q;
    end
  end
endmodule

// File: rtl/coal_irq_chk.sv
module coal_irq_chk #(
  parameter int FLUSH_CYCLES = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pkt_done,
  input logic       chan_run,
  input logic       chan_flushing,
  input logic       irq,
  input logic [2:0] stat,
  input logic [7:0] cnt,
  input logic [7:0] dly_field,
  input logic       set_done,
  input logic       set_dly
);
  localparam int BL_W = $clog2(FLUSH_CYCLES + 2) + 1;
  logic [BL_W-1:0] busy_len;

  always_ff @(posedge clk) begin
    if (!rst_n || !chan_flushing) busy_len <= '0;
    else                          busy_len <= busy_len + 1'b1;
  end

  assert_done_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |=> (cnt == 8'd0));
  assert_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && !chan_run) |=> (cnt <= $past(cnt)));
  assert_dly_cond_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_dly |-> (dly_field != 8'd0 && cnt != 8'd0));
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |=> stat[0]);
  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == 3'b000) |-> !irq);
  assert_flush_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_len <= BL_W'(FLUSH_CYCLES));
  assert_flush_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chan_flushing) |-> (stat == 3'b000 && cnt == 8'd0));
  assert_run_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chan_flushing |-> !chan_run);
endmodule

bind coal_irq_unit coal_irq_chk #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .chan_run(chan_run),
  .chan_flushing(chan_flushing), .irq(irq), .stat(stat_q), .cnt(pend_cnt),
  .dly_field(dly_cfg), .set_done(set_done), .set_dly(set_dly)
);

// File: tb/tb_coal_irq_unit.sv
module tb_coal_irq_unit;
  localparam int PRE = 8;
  localparam int FL  = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pkt_done = 1'b0;
  logic        dma_err = 1'b0;
  logic        irq, chan_run, chan_flushing;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int          kind_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  coal_irq_unit #(.PRESCALE(PRE), .FLUSH_CYCLES(FL), .ADDR_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pkt_done(pkt_done),
    .dma_err(dma_err), .irq(irq), .chan_run(chan_run),
    .chan_flushing(chan_flushing)
  );

  // monitor: compare queued expectations half a cycle after the edge
  always @(negedge clk) begin
    while (kind_q.size() > 0) begin
      int k;
      logic [31:0] e, a;
      string t;
      k = kind_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      case (k)
        0: a = reg_rdata;
        1: a = {31'd0, irq};
        2: a = {31'd0, chan_run};
        default: a = {31'd0, chan_flushing};
      endcase
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s actual %h expected %h", t, a, e);
      end
    end
  end

  function automatic logic [31:0] mk(input logic [7:0] d, input logic [7:0] th,
                                     input logic [2:0] ie, input logic run);
    return {d, th, 1'b0, ie, 9'd0, 1'b0, 1'b0, run};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0;
  endtask

  // samples state after the latest edge, then consumes one edge
  task automatic chk_rd(input logic [3:0] a, input logic [31:0] e, input string t);
    reg_addr = a;
    kind_q.push_back(0); exp_q.push_back(e); tag_q.push_back(t);
    tick(1);
  endtask

  task automatic chk_sig(input int k, input logic v, input string t);
    kind_q.push_back(k); exp_q.push_back({31'd0, v}); tag_q.push_back(t);
  endtask

  task automatic done_pulse(input int n);
    for (int i = 0; i < n; i++) begin
      pkt_done = 1'b1;
      tick(1);
      pkt_done = 1'b0;
    end
  endtask

  task automatic err_pulse();
    dma_err = 1'b1;
    tick(1);
    dma_err = 1'b0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    // R1 reset state
    chk_sig(1, 1'b0, "R1 irq");
    chk_rd(4'h0, 32'hFE18_0000, "R1 ctrl");
    chk_rd(4'h4, 32'h0, "R1 stat");
    // R2 readback, reserved bits zero
    wr(4'h0, 32'hFFFF_FFFB);
    chk_rd(4'h0, 32'hFFFF_7001, "R2 ctrl readback");
    chk_sig(2, 1'b1, "R10 run out");
    // R3 threshold, R8 irq, R7 clear
    wr(4'h0, mk(8'd0, 8'd3, 3'b001, 1'b1));
    done_pulse(2);
    chk_rd(4'h4, 32'h0, "R3 below threshold");
    chk_sig(1, 1'b0, "R8 irq low");
    done_pulse(1);
    chk_sig(1, 1'b1, "R8 irq high");
    chk_rd(4'h4, 32'h0000_1000, "R3 threshold hit");
    wr(4'h4, 32'h0);
    chk_rd(4'h4, 32'h0000_1000, "R7 zero write keeps");
    wr(4'h4, 32'h0000_1000);
    chk_rd(4'h4, 32'h0, "R7 one clears");
    chk_sig(1, 1'b0, "R8 irq cleared");
    done_pulse(3);
    chk_rd(4'h4, 32'h0000_1000, "R3 reload");
    wr(4'h4, 32'h0000_7000);
    wr(4'h0, mk(8'd0, 8'd0, 3'b001, 1'b1));
    done_pulse(1);
    chk_rd(4'h4, 32'h0000_1000, "R3 zero threshold");
    wr(4'h4, 32'h0000_7000);
    // R4 stopped
    wr(4'h0, mk(8'd0, 8'd2, 3'b001, 1'b0));
    done_pulse(1);
    chk_sig(2, 1'b0, "R10 run low");
    wr(4'h0, mk(8'd0, 8'd2, 3'b001, 1'b1));
    done_pulse(1);
    chk_rd(4'h4, 32'h0, "R4 stopped pulse ignored");
    done_pulse(1);
    chk_rd(4'h4, 32'h0000_1000, "R4 running count");
    wr(4'h4, 32'h0000_7000);
    // R5 delay timer, 3 ticks of PRE cycles
    wr(4'h0, mk(8'd3, 8'd10, 3'b010, 1'b1));
    done_pulse(1);
    tick(3 * PRE - 1);
    chk_rd(4'h4, 32'h0, "R5 before expiry");
    chk_rd(4'h4, 32'h0000_2000, "R5 expiry");
    chk_sig(1, 1'b1, "R8 delay irq");
    wr(4'h4, 32'h0000_7000);
    done_pulse(1);
    tick(10);
    done_pulse(1);
    tick(3 * PRE - 1);
    chk_rd(4'h4, 32'h0, "R5 restart");
    chk_rd(4'h4, 32'h0000_2000, "R5 restart expiry");
    wr(4'h4, 32'h0000_7000);
    wr(4'h0, mk(8'd0, 8'd10, 3'b011, 1'b1));
    done_pulse(9);
    tick(200);
    chk_rd(4'h4, 32'h0, "R5 expiry cleared count, zero bound disables");
    // R6 error
    wr(4'h0, mk(8'd0, 8'd10, 3'b000, 1'b1));
    err_pulse();
    chk_rd(4'h4, 32'h0000_4000, "R6 error");
    chk_sig(1, 1'b0, "R8 error masked");
    wr(4'h0, mk(8'd0, 8'd10, 3'b100, 1'b1));
    chk_sig(1, 1'b1, "R8 error enabled");
    tick(1);
    // R7 set wins over simultaneous clear
    reg_wr = 1'b1; reg_addr = 4'h4; reg_wdata = 32'h0000_4000; dma_err = 1'b1;
    tick(1);
    reg_wr = 1'b0; dma_err = 1'b0;
    chk_rd(4'h4, 32'h0000_4000, "R7 set wins");
    // R9 soft reset
    wr(4'h0, mk(8'd0, 8'd5, 3'b000, 1'b1));
    done_pulse(3);
    wr(4'h4, 32'h0000_7000);
    wr(4'h0, 32'h0305_7005);
    chk_rd(4'h0, 32'h0305_7005, "R9 busy bit");
    chk_sig(3, 1'b1, "R10 flushing");
    chk_sig(2, 1'b0, "R10 run gated");
    wr(4'h0, 32'h0);
    err_pulse();
    chk_rd(4'h4, 32'h0, "R9 error ignored");
    tick(FL - 5);
    chk_rd(4'h0, 32'h0305_7005, "R9 still flushing, write ignored");
    chk_rd(4'h0, 32'hFE18_0000, "R9 defaults restored");
    chk_sig(3, 1'b0, "R10 flush done");
    wr(4'h0, mk(8'd0, 8'd3, 3'b001, 1'b1));
    done_pulse(2);
    chk_rd(4'h4, 32'h0, "R9 count cleared");
    done_pulse(1);
    chk_rd(4'h4, 32'h0000_1000, "R9 count from zero");
    tick(2);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule